// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that shares a snooping bus with other caches. Each line is Invalid, Shared, Exclusive, Owned or Modified. The block serves read and write requests from its own core. It issues bus transactions for misses, upgrades and dirty evictions, and it answers transactions from other caches that it observes on the bus. Its answers are a shared indication and an intervention pulse, which means this cache supplies the line instead of memory. The policy is write-invalidate: a local write first removes every other copy of the line.

The core side is a valid/ready stream. A request transfers on a clock edge where `core_req_valid` and `core_req_ready` are both high. `core_req_ready` is low while an earlier request is still in progress and in any cycle that carries a snoop. The request must stay stable until it transfers. The bus side works like a stream that waits for a grant. `bus_req_valid` stays high until `bus_gnt` accepts it, and while it waits the address does not change. A grant has no effect in a cycle that carries a snoop, because the bus carries only one transaction per cycle. At the grant, the other caches' shared answer for a read is sampled from `bus_shared_in`.

Bus and snoop command encoding: 0 = read, 1 = read-exclusive, 2 = upgrade/invalidate, 3 = writeback. An address is a line address. Its low log2(SETS) bits select the set, and the remaining bits form the tag.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. `core_req_ready` is high, and `bus_req_valid`, `snp_shared` and `snp_intervene` are low. A snooped read to any line gives no response.
- R2: A read miss issues command 0 at the request address. If `bus_shared_in` is low at the grant, the line fills as Exclusive. A later snooped read then gives shared with no intervention.
- R3: A read miss granted with `bus_shared_in` high fills as Shared. A later local write to that line issues command 2.
- R4: A local write to an Exclusive line completes with no bus transaction and makes the line Modified.
- R5: A snooped read that hits a Modified line raises `snp_shared` and `snp_intervene` and moves the line to Owned. An Owned line intervenes on every further snooped read. A local write to an Owned line issues command 2.
- R6: A snooped command 1 or 2 that hits a valid line makes it Invalid. For command 1, `snp_intervene` is raised if the line was Modified or Owned. Command 2 gives no response. A later local read misses.
- R7: A miss whose victim is Modified or Owned first issues command 3 at the victim address, then the fill. An Exclusive or Shared victim is dropped with no writeback.
- R8: A write miss issues command 1 and fills as Modified.
- R9: `bus_req_valid`, once raised, stays high with a stable address until granted. `core_req_ready` is low while a request is in progress or `snp_valid` is high.
- R10: A snooped writeback (command 3), or a snoop whose tag does not match, gives no response and leaves the line unchanged.
- R11: If a pending upgrade loses its line to a snoop before the grant, the request turns into command 1.
- R12: `core_done` pulses in the cycle after a hit is accepted, or in the cycle after the fill's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Controller can accept a request |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Line address of the request |
| core_done | output | 1 | Request completed (pulse) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | Bus command (encoding above) |
| bus_req_addr | output | ADDR_W | Bus transaction line address |
| bus_gnt | input | 1 | Grant; transaction completes on this edge |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at grant) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line (cycle after snoop) |
| snp_intervene | output | 1 | This cache supplies the snooped line (cycle after snoop) |

## Verification
The assertions check, on every cycle, the handshake rules that hold whatever the line states are. A waiting bus request stays valid with a steady address. No request is outstanding while the core side is ready. Snoop responses appear only the cycle after a snoop, and never for upgrades or writebacks. Completions occur only right after an acceptance or a grant. The state transitions can be seen only through the bench's scenarios: Exclusive versus Shared fills, the silent upgrade, Modified moving to Owned, invalidation with intervention, ordered writeback before fill, and the race where an upgrade turns into a read-exclusive. Each scenario reads the state back through later snoops and requests.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_O, ST_M} line_st_t;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3} bus_cmd_t;

  function automatic logic is_dirty(line_st_t s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_line_table.sv
module moesi_line_table
  import moesi_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  line_st_t         wst,
  input  logic [TAG_W-1:0] wtag,
  input  logic [IDX_W-1:0] ridx_a,
  output line_st_t         rst_a,
  output logic [TAG_W-1:0] rtag_a,
  input  logic [IDX_W-1:0] ridx_b,
  output line_st_t         rst_b,
  output logic [TAG_W-1:0] rtag_b
);
  line_st_t         st_vec  [SETS];
  logic [TAG_W-1:0] tag_vec [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    line_st_t         st_q;
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        st_q  <= wst;
        tag_q <= wtag;
      end
    end
    assign st_vec[g]  = st_q;
    assign tag_vec[g] = tag_q;
  end

  assign rst_a  = st_vec[ridx_a];
  assign rtag_a = tag_vec[ridx_a];
  assign rst_b  = st_vec[ridx_b];
  assign rtag_b = tag_vec[ridx_b];
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             upd_en,
  output line_st_t         upd_st,
  output logic             snp_shared,
  output logic             snp_intervene
);
  logic hit, shared_d, int_d;

  always_comb begin
    hit      = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    upd_st   = line_st;
    shared_d = 1'b0;
    int_d    = 1'b0;
    if (hit) begin
      unique case (snp_cmd)
        CMD_RD: begin
          shared_d = 1'b1;
          int_d    = is_dirty(line_st);
          if (line_st == ST_M) upd_st = ST_O;
          else if (line_st == ST_E) upd_st = ST_S;
        end
        CMD_RDX: begin
          int_d  = is_dirty(line_st);
          upd_st = ST_I;
        end
        CMD_UPG: upd_st = ST_I;
        default: upd_st = line_st;
      endcase
    end
    upd_en = hit && (upd_st != line_st);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_shared    <= 1'b0;
      snp_intervene <= 1'b0;
    end else begin
      snp_shared    <= shared_d;
      snp_intervene <= int_d;
    end
  end
endmodule

// File: rtl/moesi_core_fsm.sv
module moesi_core_fsm
  import moesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_req_valid,
  input  logic             core_req_write,
  input  logic [IDX_W-1:0] core_req_idx,
  input  logic [TAG_W-1:0] core_req_tag,
  output logic             core_req_ready,
  output logic             core_done,
  input  logic             snp_valid,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  output logic             bus_req_valid,
  output bus_cmd_t         bus_req_cmd,
  output logic [IDX_W-1:0] bus_req_idx,
  output logic [TAG_W-1:0] bus_req_tag,
  output logic [IDX_W-1:0] lk_idx,
  input  line_st_t         lk_st,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             wr_en,
  output line_st_t         wr_st,
  output logic [TAG_W-1:0] wr_tag
);
  typedef enum logic [1:0] {PH_IDLE, PH_EVICT, PH_FILL} phase_t;

  phase_t           ph_q, ph_d;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             r_wr;
  logic             done_d, accept, tag_hit, granted;
  logic [TAG_W-1:0] cur_tag;

  always_comb begin
    core_req_ready = (ph_q == PH_IDLE) && !snp_valid;
    accept         = core_req_valid && core_req_ready;
    granted        = bus_gnt && !snp_valid;
    lk_idx         = (ph_q == PH_IDLE) ? core_req_idx : r_idx;
    cur_tag        = (ph_q == PH_IDLE) ? core_req_tag : r_tag;
    tag_hit        = (lk_st != ST_I) && (lk_tag == cur_tag);
    bus_req_valid  = 1'b0;
    bus_req_cmd    = CMD_RD;
    bus_req_idx    = r_idx;
    bus_req_tag    = r_tag;
    wr_en          = 1'b0;
    wr_st          = lk_st;
    wr_tag         = lk_tag;
    ph_d           = ph_q;
    done_d         = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          if (!core_req_write && tag_hit) begin
            done_d = 1'b1;
          end else if (core_req_write && tag_hit && (lk_st == ST_M || lk_st == ST_E)) begin
            done_d = 1'b1;
            if (lk_st == ST_E) begin
              wr_en = 1'b1;
              wr_st = ST_M;
            end
          end else if (!tag_hit && is_dirty(lk_st)) begin
            ph_d = PH_EVICT;
          end else begin
            ph_d = PH_FILL;
          end
        end
      end
      PH_EVICT: begin
        if (is_dirty(lk_st)) begin
          bus_req_valid = 1'b1;
          bus_req_cmd   = CMD_WB;
          bus_req_tag   = lk_tag;
          if (granted) begin
            wr_en = 1'b1;
            wr_st = ST_I;
            ph_d  = PH_FILL;
          end
        end else begin
          ph_d = PH_FILL;
        end
      end
      default: begin
        bus_req_valid = 1'b1;
        if (!r_wr) bus_req_cmd = CMD_RD;
        else if (tag_hit && (lk_st == ST_S || lk_st == ST_O)) bus_req_cmd = CMD_UPG;
        else bus_req_cmd = CMD_RDX;
        if (granted) begin
          wr_en  = 1'b1;
          wr_tag = r_tag;
          wr_st  = r_wr ? ST_M : (bus_shared_in ? ST_S : ST_E);
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      r_idx     <= '0;
      r_tag     <= '0;
      r_wr      <= 1'b0;
      core_done <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      core_done <= done_d;
      if (accept) begin
        r_idx <= core_req_idx;
        r_tag <= core_req_tag;
        r_wr  <= core_req_write;
      end
    end
  end
endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  output logic              core_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_intervene
);
  logic [IDX_W-1:0] lk_idx, b_idx;
  logic [TAG_W-1:0] lk_tag, sn_tag, b_tag, f_wtag;
  line_st_t         lk_st, sn_st, f_wst, s_ust;
  bus_cmd_t         f_cmd;
  logic             f_we, s_upd;

  moesi_line_table #(.SETS(SETS), .TAG_W(TAG_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (s_upd || f_we),
    .widx   (s_upd ? snp_addr[IDX_W-1:0] : lk_idx),
    .wst    (s_upd ? s_ust : f_wst),
    .wtag   (s_upd ? sn_tag : f_wtag),
    .ridx_a (lk_idx),
    .rst_a  (lk_st),
    .rtag_a (lk_tag),
    .ridx_b (snp_addr[IDX_W-1:0]),
    .rst_b  (sn_st),
    .rtag_b (sn_tag)
  );

  moesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk           (clk),
    .rst_n         (rst_n),
    .snp_valid     (snp_valid),
    .snp_cmd       (bus_cmd_t'(snp_cmd)),
    .snp_tag       (snp_addr[ADDR_W-1:IDX_W]),
    .line_st       (sn_st),
    .line_tag      (sn_tag),
    .upd_en        (s_upd),
    .upd_st        (s_ust),
    .snp_shared    (snp_shared),
    .snp_intervene (snp_intervene)
  );

  moesi_core_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_req_valid (core_req_valid),
    .core_req_write (core_req_write),
    .core_req_idx   (core_req_addr[IDX_W-1:0]),
    .core_req_tag   (core_req_addr[ADDR_W-1:IDX_W]),
    .core_req_ready (core_req_ready),
    .core_done      (core_done),
    .snp_valid      (snp_valid),
    .bus_gnt        (bus_gnt),
    .bus_shared_in  (bus_shared_in),
    .bus_req_valid  (bus_req_valid),
    .bus_req_cmd    (f_cmd),
    .bus_req_idx    (b_idx),
    .bus_req_tag    (b_tag),
    .lk_idx         (lk_idx),
    .lk_st          (lk_st),
    .lk_tag         (lk_tag),
    .wr_en          (f_we),
    .wr_st          (f_wst),
    .wr_tag         (f_wtag)
  );

  assign bus_req_cmd  = f_cmd;
  assign bus_req_addr = {b_tag, b_idx};
endmodule

// File: rtl/moesi_ctrl_chk.sv
module moesi_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic              core_done,
  input logic              bus_req_valid,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_intervene
);
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt && !snp_valid |=> bus_req_valid && $stable(bus_req_addr));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_ready |-> !bus_req_valid);

  p_resp_after_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_shared || snp_intervene) |-> $past(snp_valid));

  p_upg_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snp_valid && snp_cmd == 2'd2) |-> !snp_shared && !snp_intervene);

  p_wb_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snp_valid && snp_cmd == 2'd3) |-> !snp_shared && !snp_intervene);

  p_done_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> $past(core_req_valid && core_req_ready) || $past(bus_req_valid && bus_gnt && !snp_valid));
endmodule

bind moesi_ctrl moesi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_ready (core_req_ready),
  .core_done      (core_done),
  .bus_req_valid  (bus_req_valid),
  .bus_req_addr   (bus_req_addr),
  .bus_gnt        (bus_gnt),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_shared     (snp_shared),
  .snp_intervene  (snp_intervene)
);

// File: tb/moesi_ctrl_test.sv
`timescale 1ns/1ps
module moesi_ctrl_test;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_ADR = 16'h0011, B_ADR = 16'h0019, C_ADR = 16'h0022;
  localparam logic [AW-1:0] D_ADR = 16'h0033, E_ADR = 16'h0044, F_ADR = 16'h003B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_req_valid = 1'b0, core_req_write = 1'b0;
  logic [AW-1:0] core_req_addr = '0;
  logic core_req_ready, core_done, bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_intervene;

  int errors = 0, checks = 0;
  int rec_n;
  logic [1:0] rec_cmd [4];
  logic [AW-1:0] rec_addr [4];
  logic first_done, got_done, finished = 1'b0;

  always #2 clk = ~clk;

  moesi_ctrl uut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic core_op(input logic wr, input logic [AW-1:0] adr, input logic shr);
    rec_n = 0; first_done = 0; got_done = 0;
    while (!core_req_ready) @(negedge clk);
    core_req_valid = 1; core_req_write = wr; core_req_addr = adr;
    @(negedge clk);
    core_req_valid = 0;
    first_done = core_done;
    for (int i = 0; i < 40; i++) begin
      if (core_done) begin got_done = 1; break; end
      if (bus_req_valid) begin
        if (rec_n < 4) begin rec_cmd[rec_n] = bus_req_cmd; rec_addr[rec_n] = bus_req_addr; end
        rec_n++;
        bus_gnt = 1; bus_shared_in = shr;
        @(negedge clk);
        bus_gnt = 0; bus_shared_in = 0;
      end else @(negedge clk);
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] adr);
    snp_valid = 1; snp_cmd = cmd; snp_addr = adr;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset();
    chk(core_req_ready == 1 && bus_req_valid == 0, "R1 idle", {core_req_ready, bus_req_valid}, 2);
    chk(!snp_shared && !snp_intervene, "R1 resp", {snp_shared, snp_intervene}, 0);
    snoop(2'd0, A_ADR);
    chk(!snp_shared && !snp_intervene, "R1 invalid line", {snp_shared, snp_intervene}, 0);
  endtask

  task automatic t_excl_modified_owned();
    core_op(0, A_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 0 && rec_addr[0] == A_ADR && got_done, "R2 read miss", rec_cmd[0], 0);
    core_op(1, A_ADR, 0);
    chk(rec_n == 0 && first_done, "R4 silent E->M", rec_n, 0);
    chk(first_done, "R12 hit done next cycle", first_done, 1);
    snoop(2'd0, A_ADR);
    chk(snp_shared && snp_intervene, "R5 M snooped read", {snp_shared, snp_intervene}, 3);
    snoop(2'd0, A_ADR);
    chk(snp_shared && snp_intervene, "R5 owner intervenes", {snp_shared, snp_intervene}, 3);
    core_op(1, A_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 2 && got_done, "R5 O write upgrade", rec_cmd[0], 2);
  endtask

  task automatic t_replace();
    core_op(0, B_ADR, 1);
    chk(rec_n == 2 && rec_cmd[0] == 3 && rec_addr[0] == A_ADR, "R7 dirty victim wb", rec_addr[0], A_ADR);
    chk(rec_cmd[1] == 0 && rec_addr[1] == B_ADR, "R7 fill after wb", rec_addr[1], B_ADR);
    core_op(0, A_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 0, "R7 S victim silent", rec_n, 1);
    snoop(2'd0, A_ADR);
    chk(snp_shared && !snp_intervene, "R2 E on snooped read", {snp_shared, snp_intervene}, 2);
    core_op(0, B_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 0, "R7 clean victim silent", rec_n, 1);
  endtask

  task automatic t_shared_fill();
    core_op(0, C_ADR, 1);
    chk(rec_n == 1 && rec_cmd[0] == 0, "R3 read miss", rec_cmd[0], 0);
    snoop(2'd0, C_ADR);
    chk(snp_shared && !snp_intervene, "R3 S snooped read", {snp_shared, snp_intervene}, 2);
    core_op(1, C_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 2 && rec_addr[0] == C_ADR, "R3 S write upgrade", rec_cmd[0], 2);
  endtask

  task automatic t_invalidate();
    snoop(2'd1, C_ADR);
    chk(snp_intervene && !snp_shared, "R6 rdx on M", {snp_shared, snp_intervene}, 1);
    core_op(0, C_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 0, "R6 read misses after rdx", rec_n, 1);
    snoop(2'd2, C_ADR);
    chk(!snp_intervene && !snp_shared, "R6 upg silent", {snp_shared, snp_intervene}, 0);
    core_op(0, C_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 0, "R6 read misses after upg", rec_n, 1);
  endtask

  task automatic t_write_miss();
    core_op(1, D_ADR, 0);
    chk(rec_n == 1 && rec_cmd[0] == 1 && rec_addr[0] == D_ADR, "R8 write miss rdx", rec_cmd[0], 1);
    snoop(2'd3, D_ADR);
    chk(!snp_shared && !snp_intervene, "R10 snooped wb", {snp_shared, snp_intervene}, 0);
    snoop(2'd0, F_ADR);
    chk(!snp_shared && !snp_intervene, "R10 tag mismatch", {snp_shared, snp_intervene}, 0);
    snoop(2'd0, D_ADR);
    chk(snp_shared && snp_intervene, "R8 filled M unchanged", {snp_shared, snp_intervene}, 3);
  endtask

  task automatic t_upgrade_race();
    logic [AW-1:0] a0;
    core_op(0, E_ADR, 1);
    core_req_valid = 1; core_req_write = 1; core_req_addr = E_ADR;
    @(negedge clk);
    core_req_valid = 0;
    a0 = bus_req_addr;
    for (int i = 0; i < 3; i++) begin
      chk(bus_req_valid && bus_req_cmd == 2 && bus_req_addr == a0 && !core_req_ready,
          "R9 request held", {bus_req_valid, bus_req_cmd}, 6);
      @(negedge clk);
    end
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = E_ADR;
    chk(!core_req_ready, "R9 ready low in snoop", core_req_ready, 0);
    @(negedge clk);
    snp_valid = 0;
    chk(!snp_intervene, "R6 S rdx no intervene", snp_intervene, 0);
    chk(bus_req_valid && bus_req_cmd == 1 && bus_req_addr == E_ADR, "R11 upgrade becomes rdx", bus_req_cmd, 1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(core_done, "R12 done after grant", core_done, 1);
    snoop(2'd0, E_ADR);
    chk(snp_intervene, "R11 line now M", snp_intervene, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_excl_modified_owned();
    t_replace();
    t_shared_fill();
    t_invalidate();
    t_write_miss();
    t_upgrade_race();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule